// File: doc/BRIEF.md
# Status-Word Flag Write Unit

This unit carries out the legacy "load status word" operation at retirement. It takes a 16-bit operand that has already been fetched and writes only its four lowest bits into the low flag field of a 32-bit processor control register. Before it writes, it checks the current operating mode, the privilege level and the lock-prefix indication. A request that fails these checks produces a one-cycle fault pulse with a fault code and leaves the register as it was. A request that passes updates the register and produces a one-cycle serialize request, so that later operations wait until the write has completed.

Bit 0 of the register is the protection-enable flag, and it is sticky on this path. A write can set it, which switches the processor to protected operation, but no write through this unit can clear it. Bits 1 to 3 are the coprocessor-monitor, emulation and task-switched flags, and they take the operand value directly. All register bits from bit 4 upward keep their values.

The unit is built around a three-state outcome machine. `ST_IDLE` means no request was seen at the last edge. `ST_COMMIT` means the last request was written. `ST_FAULT` means the last request was refused. The machine leaves every state the same way: with no request it goes to `ST_IDLE`; with a request that raises a fault it goes to `ST_FAULT`; with any other request it goes to `ST_COMMIT`. Each state therefore lasts exactly one cycle unless the next request leads to the same outcome.

Top module: `msw_write_unit`

## Requirements
- R1: After reset, `ctrl_o` is 0x00000010, and `fault_o`, `serialize_o` and `pe_switch_o` are 0.
- R2: On a request with no fault, `ctrl_o[3:1]` takes `src_i[3:1]` at the clock edge after the request. `ctrl_o[31:4]` keeps its value. `src_i[15:4]` has no effect on the result.
- R3: Bit 0 of `ctrl_o` is set by a successful write that has `src_i[0]`=1. Once bit 0 is 1, it stays 1 whatever the operand.
- R4: `pe_switch_o` pulses for one cycle, in the cycle after the request, only when a successful write changes bit 0 from 0 to 1.
- R5: When `lock_i`=1, a request produces fault code 2'b01 (invalid opcode) in every mode and leaves `ctrl_o` unchanged.
- R6: In virtual-8086 mode (`mode_i`=2'b10), a request produces fault code 2'b10 (general protection, error code 0) at any privilege level and leaves `ctrl_o` unchanged.
- R7: In protected mode (`mode_i`=2'b01, with 2'b11 treated the same way), a request with `cpl_i`≠0 produces fault code 2'b10 and leaves `ctrl_o` unchanged. In real mode (`mode_i`=2'b00), no privilege check is made.
- R8: Faults are ranked in this order: lock first, then virtual-8086, then privilege. Each faulting request reports exactly one code. `fault_code_o` is 2'b00 whenever `fault_o` is 0.
- R9: `fault_o` and `serialize_o` are single-cycle pulses in the cycle after the request. `serialize_o` follows each successful write, `fault_o` follows each refused request, and the two are never high together.
- R10: Without `req_i`, the register does not change and none of the pulses is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, one per operation |
| src_i | input | 16 | Source operand |
| mode_i | input | 2 | 00 real, 01 protected, 10 virtual-8086, 11 treated as protected |
| cpl_i | input | 2 | Current privilege level |
| lock_i | input | 1 | Lock prefix present |
| ctrl_o | output | 32 | Control register |
| pe_switch_o | output | 1 | Pulse on the switch to protected operation |
| fault_o | output | 1 | Fault pulse |
| fault_code_o | output | 2 | 01 invalid opcode, 10 general protection (error 0) |
| serialize_o | output | 1 | Serialize request pulse |

## Verification
A wrong outcome state shows up at the ports in the cycle right after the request. It appears as a missing, doubled or mixed-up `serialize_o` or `fault_o` pulse, or as a fault code of the wrong rank. A fault in the merge logic shows in `ctrl_o` at the same edge, for example a cleared protection-enable bit or a changed upper bit. That error then stays in the register for every later comparison. The random stream mixes all four mode codes, every privilege level and the lock prefix, and a second reset brings back the 0-to-1 switch of the protection-enable bit.

// File: rtl/msw_pkg.sv
package msw_pkg;
    localparam logic [1:0] MODE_REAL = 2'b00;
    localparam logic [1:0] MODE_PROT = 2'b01;
    localparam logic [1:0] MODE_V86  = 2'b10;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_UD   = 2'b01,
        FLT_GP   = 2'b10
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_COMMIT = 2'b01,
        ST_FAULT  = 2'b10
    } st_e;
endpackage

// File: rtl/msw_fault_check.sv
module msw_fault_check
    import msw_pkg::*;
#(
    parameter int CPL_W = 2
) (
    input  logic             lock_i,
    input  logic [1:0]       mode_i,
    input  logic [CPL_W-1:0] cpl_i,
    output flt_e             kind_o
);
    always_comb begin
        if (lock_i) begin
            kind_o = FLT_UD;
        end else if (mode_i == MODE_V86) begin
            kind_o = FLT_GP;
        end else if ((mode_i != MODE_REAL) && (cpl_i != '0)) begin
            kind_o = FLT_GP;
        end else begin
            kind_o = FLT_NONE;
        end
    end
endmodule

// File: rtl/msw_flag_merge.sv
module msw_flag_merge #(
    parameter int REG_W  = 32,
    parameter int SRC_W  = 16,
    parameter int FLAG_W = 4
) (
    input  logic [REG_W-1:0] cur_i,
    input  logic [SRC_W-1:0] src_i,
    output logic [REG_W-1:0] next_o,
    output logic             pe_rise_o
);
    logic unused_hi;
    assign unused_hi = ^src_i[SRC_W-1:FLAG_W];

    always_comb begin
        next_o                     = cur_i;
        next_o[FLAG_W-1:1]         = src_i[FLAG_W-1:1];
        next_o[0]                  = cur_i[0] | src_i[0];
        pe_rise_o                  = src_i[0] & ~cur_i[0];
    end
endmodule

// File: rtl/msw_write_unit.sv
module msw_write_unit
    import msw_pkg::*;
#(
    parameter int          REG_W     = 32,
    parameter int          SRC_W     = 16,
    parameter int          FLAG_W    = 4,
    parameter int          CPL_W     = 2,
    parameter logic [31:0] RESET_VAL = 32'h0000_0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [1:0]        mode_i,
    input  logic [CPL_W-1:0]  cpl_i,
    input  logic              lock_i,
    output logic [REG_W-1:0]  ctrl_o,
    output logic              pe_switch_o,
    output logic              fault_o,
    output logic [1:0]        fault_code_o,
    output logic              serialize_o
);
    localparam logic [REG_W-1:0] RST_REG = RESET_VAL[REG_W-1:0];

    st_e              state_q, state_d;
    flt_e             kind, code_q;
    logic [REG_W-1:0] ctrl_q, ctrl_next;
    logic             pe_rise, pe_sw_q;

    msw_fault_check #(.CPL_W(CPL_W)) chk_i (
        .lock_i (lock_i),
        .mode_i (mode_i),
        .cpl_i  (cpl_i),
        .kind_o (kind)
    );

    msw_flag_merge #(.REG_W(REG_W), .SRC_W(SRC_W), .FLAG_W(FLAG_W)) mrg_i (
        .cur_i     (ctrl_q),
        .src_i     (src_i),
        .next_o    (ctrl_next),
        .pe_rise_o (pe_rise)
    );

    always_comb begin
        if (!req_i)                 state_d = ST_IDLE;
        else if (kind != FLT_NONE)  state_d = ST_FAULT;
        else                        state_d = ST_COMMIT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= RST_REG;
            pe_sw_q <= 1'b0;
            code_q  <= FLT_NONE;
        end else begin
            pe_sw_q <= 1'b0;
            code_q  <= req_i ? kind : FLT_NONE;
            if (state_d == ST_COMMIT) begin
                ctrl_q  <= ctrl_next;
                pe_sw_q <= pe_rise;
            end
        end
    end

    always_comb begin
        serialize_o  = 1'b0;
        fault_o      = 1'b0;
        fault_code_o = FLT_NONE;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COMMIT: serialize_o = 1'b1;
            ST_FAULT: begin
                fault_o      = 1'b1;
                fault_code_o = code_q;
            end
            default:   ;
        endcase
    end

    assign ctrl_o      = ctrl_q;
    assign pe_switch_o = pe_sw_q;

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_o && serialize_o));
    // R5
    fault_keeps_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $stable(ctrl_o));
    // R3
    pe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[0] |=> ctrl_o[0]);
    // R10
    idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(ctrl_o) && !serialize_o && !fault_o));
    // R2
    upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(ctrl_o[REG_W-1:FLAG_W]));
    // R4
    switch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_switch_o |-> (ctrl_o[0] && !$past(ctrl_o[0]) && serialize_o));
    // R8
    one_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o == ($countones(fault_code_o) == 1));
endmodule

// File: tb/msw_write_unit_tb_top.sv
module msw_write_unit_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic [15:0] src;
    logic [1:0]  mode;
    logic [1:0]  cpl;
    logic        lock;
    logic [31:0] ctrl;
    logic        pe_sw, flt, ser;
    logic [1:0]  fcode;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_reg;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    msw_write_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .src_i(src), .mode_i(mode),
        .cpl_i(cpl), .lock_i(lock), .ctrl_o(ctrl), .pe_switch_o(pe_sw),
        .fault_o(flt), .fault_code_o(fcode), .serialize_o(ser)
    );

    function automatic logic [1:0] exp_kind(logic lk, logic [1:0] md, logic [1:0] pl);
        if (lk)                      return 2'b01;
        if (md == 2'b10)             return 2'b10;
        if (md != 2'b00 && pl != 0)  return 2'b10;
        return 2'b00;
    endfunction

    function automatic string req_tag(logic rq, logic lk, logic [1:0] md, logic [1:0] pl);
        if (!rq)                     return "R10";
        if (lk)                      return "R5";
        if (md == 2'b10)             return "R6";
        if (md != 2'b00 && pl != 0)  return "R7";
        return "R2";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = 1'b0; src = '0; mode = 2'b00; cpl = '0; lock = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_reg = 32'h0000_0010;
        chk("R1 ctrl", ctrl, 32'h10);
        chk("R1 pulses", {29'd0, pe_sw, flt, ser}, 32'd0);
    endtask

    task automatic step(logic rq, logic [15:0] s, logic [1:0] md, logic [1:0] pl, logic lk);
        logic [1:0]  k;
        logic        ok;
        logic [31:0] nreg;
        string       t;
        req = rq; src = s; mode = md; cpl = pl; lock = lk;
        k    = exp_kind(lk, md, pl);
        ok   = rq && (k == 2'b00);
        t    = req_tag(rq, lk, md, pl);
        nreg = m_reg;
        if (ok) begin
            nreg[3:1] = s[3:1];
            nreg[0]   = m_reg[0] | s[0];
        end
        @(posedge clk);
        @(negedge clk);
        chk({t, " ctrl"}, ctrl, nreg);
        chk("R9 serialize", {31'd0, ser}, {31'd0, ok});
        chk("R9 fault", {31'd0, flt}, {31'd0, rq && !ok});
        chk("R8 code", {30'd0, fcode}, {30'd0, rq ? k : 2'b00});
        chk("R4 switch", {31'd0, pe_sw}, {31'd0, ok && s[0] && !m_reg[0]});
        chk("R3 pe", {31'd0, ctrl[0]}, {31'd0, nreg[0]});
        m_reg = nreg;
        req = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        // R2: upper operand bits ignored, real mode write
        step(1'b1, 16'hFFF6, 2'b00, 2'd3, 1'b0);
        // R10: no request
        step(1'b0, 16'h000F, 2'b00, 2'd0, 1'b0);
        // R7: protected with cpl 3 refused before PE set
        step(1'b1, 16'h0001, 2'b01, 2'd3, 1'b0);
        // R4, R3: PE rises
        step(1'b1, 16'h0001, 2'b00, 2'd0, 1'b0);
        // R3: clearing attempt keeps PE
        step(1'b1, 16'h0000, 2'b01, 2'd0, 1'b0);
        // R8: lock outranks v86
        step(1'b1, 16'h000E, 2'b10, 2'd3, 1'b1);
        // R6: v86 at cpl 0
        step(1'b1, 16'h000E, 2'b10, 2'd0, 1'b0);
        // R7: mode 11 treated as protected
        step(1'b1, 16'h000E, 2'b11, 2'd1, 1'b0);
        // R5: lock in real mode
        step(1'b1, 16'h0008, 2'b00, 2'd0, 1'b1);
        // R9: back-to-back successes
        step(1'b1, 16'h0008, 2'b01, 2'd0, 1'b0);
        step(1'b1, 16'h0004, 2'b00, 2'd2, 1'b0);
        // R1: second reset, then random traffic
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, 16'($urandom), 2'($urandom), 2'($urandom),
                 ($urandom % 8) == 0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule